// File: doc/BRIEF.md
# Multi-Bit Compression Test Mode for an Asynchronous-Strobe DRAM Core

This block is the device-side control and array logic of a small DRAM core with four data pins. The row and column strobes, the write strobe and the output enable arrive active low and are sampled on a system clock. A falling row strobe latches the row from the shared address bus, and a falling column strobe latches the column. A normal access then reads or writes one 4-bit word.

A refresh-style strobe order, with the column strobe falling before the row strobe and the write strobe low, switches the core into a latched parallel test mode. In that mode the two lowest column bits are ignored. Each data pin is tied to the same bit of four neighbouring words. A write copies the pin values into all four words. A read reports, for each pin, whether its four cells agree.

Two cycle types leave test mode. One is a row-only cycle, in which the row strobe pulses while the column strobe stays high. The other is a column-before-row refresh with the write strobe high. The bidirectional data bus is split into an input, an output and an output enable.

Top module: `tmc_dram`

## Requirements
- R1: After reset the core is in normal mode and `dq_oe` is 0.
- R2: In a normal access, the sample in which `cas_n` is first seen low while `ras_n` is low stores `dq_in` into the word at (latched row, column address), provided `we_n` is low in that sample.
- R3: In a normal read, `dq_out` equals the addressed word from the sample after the column is latched, for as long as `ras_n` and `cas_n` stay low.
- R4: `dq_oe` is 1 only inside an access cycle whose column has been latched, with `ras_n`, `cas_n` and `oe_n` low and `we_n` high. It is 0 during writes and whenever `oe_n` is high.
- R5: A sample in which `ras_n` falls while `cas_n` and `we_n` are both low enters test mode.
- R6: Test mode is held across any number of access cycles. It changes only at a sample where `ras_n` changes.
- R7: A cycle in which `ras_n` falls with `cas_n` high and rises again with no `cas_n` fall leaves test mode.
- R8: A sample in which `ras_n` falls with `cas_n` low and `we_n` high leaves test mode and changes no stored word.
- R9: A test-mode write ignores column bits [1:0] and writes `dq_in` into all four words whose column differs only in those bits.
- R10: On a test-mode read, `dq_out[p]` is 1 if bit p is equal in all four words of the group, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| dq_in | input | DQ_W | Data bus, input side |
| dq_out | output | DQ_W | Data bus, output side |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench fills a group of four words with patterns in which some pins agree and others do not. It then checks the compressed read pin by pin. A core that compared the wrong bits, or still used column bits [1:0], would return the wrong pass/fail pattern. It confirms that a test-mode write reaches all four words by reading them back one at a time after leaving test mode; a core that wrote a single word would leave three stale values. It also covers both exit orders, and checks that test mode survives several unrelated cycles. A core that exited on every refresh, or never exited, would return compare bits where plain data is expected, or the reverse.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_e;
endpackage

// File: rtl/tmc_strobe_ctl.sv
module tmc_strobe_ctl
    import tmc_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             wr_o,
    output logic             test_o,
    output logic             rd_valid_o
);
    typedef struct packed {
        cyc_e             cyc;
        logic             ras;
        logic             cas;
        logic             test;
        logic             cas_seen;
        logic             col_valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } ctl_s;

    ctl_s st_q, st_d;
    logic ras_fall, ras_rise, cas_fall, cas_rise;

    always_comb begin
        ras_fall = st_q.ras && !ras_n;
        ras_rise = !st_q.ras && ras_n;
        cas_fall = st_q.cas && !cas_n;
        cas_rise = !st_q.cas && cas_n;
        st_d     = st_q;
        st_d.ras = ras_n;
        st_d.cas = cas_n;
        wr_o     = 1'b0;
        if (ras_fall) begin
            if (!cas_n) begin
                st_d.cyc  = CYC_REFRESH;
                st_d.test = !we_n;
            end else begin
                st_d.cyc       = CYC_ACCESS;
                st_d.row       = addr[ROW_W-1:0];
                st_d.cas_seen  = 1'b0;
                st_d.col_valid = 1'b0;
            end
        end else if (ras_rise) begin
            if (st_q.cyc == CYC_ACCESS && !st_q.cas_seen)
                st_d.test = 1'b0;
            st_d.cyc       = CYC_IDLE;
            st_d.col_valid = 1'b0;
        end else if (st_q.cyc == CYC_ACCESS && !ras_n) begin
            if (cas_fall) begin
                st_d.col       = addr[COL_W-1:0];
                st_d.cas_seen  = 1'b1;
                st_d.col_valid = 1'b1;
                wr_o           = !we_n;
            end else if (cas_rise) begin
                st_d.col_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cyc       <= CYC_IDLE;
            st_q.ras       <= 1'b1;
            st_q.cas       <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o      = st_q.row;
    assign col_o      = wr_o ? addr[COL_W-1:0] : st_q.col;
    assign test_o     = st_q.test;
    assign rd_valid_o = (st_q.cyc == CYC_ACCESS) && st_q.col_valid && !ras_n && !cas_n;

    AST_TM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ras && !ras_n && !cas_n && !we_n) |=> test_o); // R5
    AST_TM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ras == ras_n) |=> $stable(test_o)); // R6
    AST_TM_EXIT_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ras && ras_n && st_q.cyc == CYC_ACCESS && !st_q.cas_seen) |=> !test_o); // R7
    AST_TM_EXIT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ras && !ras_n && !cas_n && we_n) |=> !test_o); // R8
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o); // R2
endmodule

// File: rtl/tmc_cell_array.sv
module tmc_cell_array #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             wr,
    input  logic             test,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DQ_W-1:0]  din,
    output logic [DQ_W-1:0]  dout
);
    localparam int IGN_W = 2;
    localparam int GRP   = 1 << IGN_W;
    localparam int IDX_W = ROW_W + COL_W;
    localparam int WORDS = 1 << IDX_W;

    logic [DQ_W-1:0] mem_q [WORDS];
    logic [IDX_W-1:0] idx;
    logic [DQ_W-1:0] grp_word [GRP];
    logic [DQ_W-1:0] cmp;

    assign idx = {row, col};

    always_ff @(posedge clk) begin
        if (wr) begin
            if (test) begin
                for (int k = 0; k < GRP; k++)
                    mem_q[{row, col[COL_W-1:IGN_W], IGN_W'(k)}] <= din;
            end else begin
                mem_q[idx] <= din;
            end
        end
    end

    for (genvar k = 0; k < GRP; k++) begin : g_grp
        assign grp_word[k] = mem_q[{row, col[COL_W-1:IGN_W], IGN_W'(k)}];
    end

    for (genvar p = 0; p < DQ_W; p++) begin : g_pin
        logic [GRP-1:0] bits;
        for (genvar k = 0; k < GRP; k++) begin : g_bit
            assign bits[k] = grp_word[k][p];
        end
        assign cmp[p] = (bits == '0) || (bits == '1);
    end

    assign dout = test ? cmp : mem_q[idx];
endmodule

// File: rtl/tmc_dram.sv
module tmc_dram #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DQ_W   = 4,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic wr, test, rd_valid;

    tmc_strobe_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .row_o(row), .col_o(col), .wr_o(wr), .test_o(test),
        .rd_valid_o(rd_valid)
    );

    tmc_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_arr (
        .clk(clk), .wr(wr), .test(test), .row(row), .col(col),
        .din(dq_in), .dout(dq_out)
    );

    assign dq_oe = rd_valid && !oe_n && we_n;

    AST_OE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ras_n && !cas_n && !oe_n && we_n)); // R4
    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !dq_oe); // R4
endmodule

// File: tb/tmc_dram_tb.sv
module tmc_dram_tb_top;
    localparam int ROW_W = 4, COL_W = 4, DQ_W = 4, ADDR_W = 4;
    localparam int WORDS = 1 << (ROW_W + COL_W);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0] dq_in = '0, dq_out;
    logic dq_oe;

    always #2.5 clk = ~clk;

    tmc_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        logic [DQ_W-1:0] data;
        logic            oe;
        string           req;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0, errors = 0;
    logic [DQ_W-1:0] bm [WORDS];
    logic tm = 1'b0;
    bit done = 0;

    // monitor: samples just after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (dq_oe !== e.oe || (e.oe && dq_out !== e.data)) begin
                errors++;
                $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                         e.req, dq_oe, dq_out, e.oe, e.data);
            end
        end
    end

    function automatic logic [DQ_W-1:0] model_read(input int row, input int col);
        logic [DQ_W-1:0] r;
        if (!tm) return bm[row*16 + col];
        for (int p = 0; p < DQ_W; p++) begin
            int ones = 0;
            for (int k = 0; k < 4; k++) ones += bm[row*16 + (col & 12) + k][p];
            r[p] = (ones == 0 || ones == 4);
        end
        return r;
    endfunction

    task automatic push(input logic [DQ_W-1:0] d, input logic oe, input string req);
        exp_t e;
        e.data = d; e.oe = oe; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic access(input int row, input int col, input bit wr,
                          input logic [DQ_W-1:0] d, input bit oe_low, input string req);
        addr <= ADDR_W'(row); ras_n <= 1'b0;
        @(negedge clk);
        addr <= ADDR_W'(col); cas_n <= 1'b0; we_n <= !wr; dq_in <= d; oe_n <= !oe_low;
        @(negedge clk);
        if (wr) begin
            if (tm) for (int k = 0; k < 4; k++) bm[row*16 + (col & 12) + k] = d;
            else bm[row*16 + col] = d;
            push('0, 1'b0, req);
        end else begin
            push(model_read(row, col), oe_low, req);
        end
        @(negedge clk);
        cas_n <= 1'b1; ras_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1;
        @(negedge clk);
    endtask

    task automatic cbr(input bit we_low);
        cas_n <= 1'b0; we_n <= !we_low;
        @(negedge clk);
        ras_n <= 1'b0;
        @(negedge clk);
        @(negedge clk);
        ras_n <= 1'b1;
        @(negedge clk);
        cas_n <= 1'b1; we_n <= 1'b1;
        @(negedge clk);
        tm = we_low;
    endtask

    task automatic ras_only(input int row);
        addr <= ADDR_W'(row); ras_n <= 1'b0;
        @(negedge clk);
        @(negedge clk);
        ras_n <= 1'b1;
        @(negedge clk);
        tm = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push('0, 1'b0, "R1 reset");
        @(negedge clk);
        // normal writes and reads
        access(2, 5, 1, 4'hA, 1, "R2 R4 write no drive");
        access(2, 5, 0, 0, 1, "R2 R3 read back");
        access(3, 0, 1, 4'h3, 0, "R2 write");
        access(3, 0, 0, 0, 1, "R3 read row3");
        access(2, 5, 0, 0, 0, "R4 oe_n high");
        // group at row 1 cols 8..11: pin0 mixed, others equal
        access(1, 8, 1, 4'b0110, 0, "R2 g0");
        access(1, 9, 1, 4'b0111, 0, "R2 g1");
        access(1, 10, 1, 4'b0110, 0, "R2 g2");
        access(1, 11, 1, 4'b0110, 0, "R2 g3");
        // refresh with WE high leaves data alone
        cbr(0);
        access(1, 9, 0, 0, 1, "R8 data kept");
        // enter test mode
        cbr(1);
        access(1, 10, 0, 0, 1, "R5 R10 compare pin0 fails");
        access(2, 5, 0, 0, 1, "R6 R10 still test mode");
        access(0, 6, 1, 4'b1001, 0, "R9 test write");
        access(0, 7, 0, 0, 1, "R6 R10 all equal");
        // exit via row-only
        ras_only(7);
        for (int c = 4; c < 8; c++) access(0, c, 0, 0, 1, "R7 R9 group readback");
        access(1, 8, 0, 0, 1, "R7 plain data");
        // re-enter, then exit by refresh with WE high
        cbr(1);
        access(1, 11, 0, 0, 1, "R5 re-enter compare");
        cbr(0);
        access(1, 11, 0, 0, 1, "R8 exit plain data");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule